// File: doc/BRIEF.md
# Serial PHY Management Master

This block runs the two-wire management link to an Ethernet PHY: a clock line driven by the master, and a bidirectional data line. Software composes a complete 32-bit management frame word and writes it into the frame register. The block can first send a run of 32 ones as a preamble. It then shifts the whole word out most significant bit first. On a read, it releases the data line at the turnaround and collects the 16 data bits the PHY returns.

The start code, opcode, PHY address, register address and turnaround pattern are all taken as written from the frame word. The block itself only decodes the opcode, to know whether to release the line. When a frame completes, the block sets an event flag. If the mask allows it, the flag raises an interrupt. After a read, the received data replaces the low half of the frame register. A timing register sets three things:
- the management clock divider,
- the preamble suppression,
- the data hold time after each falling clock edge.

The divider and the hold time are both counted in module-clock cycles.

Top module: `mdio_master`

## Requirements
- R1: Writing the frame register (select 0) while idle starts a transfer and raises `busy` until the frame ends. Writes to the frame register while `busy` is high leave `frame_q` unchanged.
- R2: The management clock `mdc` has a period of 2*(SPEED+1) module cycles. SPEED is the timing register field in bits 6:1. For example, SPEED = 24 at 125 MHz gives 2.5 MHz. `mdc` stays low while idle.
- R3: Unless timing register bit 7 is set, each frame begins with 32 one bits. When bit 7 is set, the frame begins directly with frame bit 31. A frame therefore spans 64 or 32 rising `mdc` edges.
- R4: Frame word bits go out from bit 31 down to bit 0, one per `mdc` period. The line changes HOLD+1 module cycles after a falling `mdc` edge, where HOLD is the timing register field in bits 10:8. The bench uses HOLD < SPEED.
- R5: When frame bits 29:28 are 10 (read), `mdio_oe` is low from frame bit 17 through bit 0. For any other opcode, `mdio_oe` stays high for the whole frame.
- R6: After a read, `frame_q[15:0]` holds the 16 bits sampled on the rising `mdc` edges of frame bits 15..0, first sample in bit 15. Bits 31:16 are unchanged. After a write, the whole frame register is unchanged.
- R7: The end of a frame sets the event flag `evt`, which is bit 23 of the event register (select 2). Writing a 1 to bit 23 there clears it. Writing a 0 has no effect.
- R8: `irq` is registered. It equals the event flag AND the mask register (select 3) bit 23 from the previous cycle.
- R9: After reset, `frame_q`, `evt`, `busy`, `irq`, `mdc` and `mdio_oe` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 frame, 1 timing, 2 event, 3 mask |
| reg_wdata | input | 32 | Register write data |
| frame_q | output | 32 | Frame register contents |
| evt | output | 1 | Frame-complete event flag |
| busy | output | 1 | Transfer in progress |
| irq | output | 1 | Masked event interrupt |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data line output value |
| mdio_oe | output | 1 | Data line output enable |
| mdio_i | input | 1 | Data line input value |

## Verification
The bench builds the block with its default widths: a 6-bit divider field and a 3-bit hold field. It sweeps every divider value from 1 to 4 against every hold value below the divider, for read and write opcodes, with and without preamble. This exercises every bit position of the serializer, including the turnaround boundary. It also checks the hold offset of every data-line change against the falling clock edge. One extra frame with a divider of 24 checks the rate example at a realistic setting.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int FRAME_W   = 32;
  localparam int PRE_LEN   = 32;
  localparam int DATA_W    = 16;
  localparam int TA_TOP    = 17;
  localparam int EVT_BIT   = 23;
  localparam int NOPRE_BIT = 7;
  localparam int SPD_LSB   = 1;
  localparam int HOLD_LSB  = 8;
  localparam logic [1:0] OP_READ = 2'b10;

  typedef enum logic [1:0] {
    SEL_FRAME  = 2'd0,
    SEL_TIMING = 2'd1,
    SEL_EVENT  = 2'd2,
    SEL_MASK   = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
  parameter int DIV_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             mdc,
  output logic             rise_stb,
  output logic             fall_stb
);
  logic [DIV_W-1:0] cnt;
  logic             mdc_q;
  logic             wrap;

  assign wrap     = run && (cnt == div);
  assign rise_stb = wrap && !mdc_q;
  assign fall_stb = wrap && mdc_q;
  assign mdc      = mdc_q;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt   <= '0;
      mdc_q <= 1'b0;
    end else if (wrap) begin
      cnt   <= '0;
      mdc_q <= ~mdc_q;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // R2: edges only while running, never both at once
  a_r2_edges_need_run: assert property (@(posedge clk) disable iff (rst)
    (rise_stb || fall_stb) |-> (run && !(rise_stb && fall_stb)));
endmodule

// File: rtl/mdio_shifter.sv
module mdio_shifter
  import mdio_pkg::*;
#(
  parameter int HOLD_W = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [FRAME_W-1:0] frame,
  input  logic               nopre,
  input  logic [HOLD_W-1:0]  hold,
  input  logic               rise_stb,
  input  logic               fall_stb,
  input  logic               mdio_i,
  output logic               active,
  output logic               mdio_o,
  output logic               mdio_oe,
  output logic               done,
  output logic [DATA_W-1:0]  rdata
);
  localparam int TOTAL = PRE_LEN + FRAME_W;
  localparam int POS_W = $clog2(TOTAL);

  logic [FRAME_W-1:0] frm_q;
  logic [POS_W-1:0]   pos;
  logic [POS_W-1:0]   pos_dn;
  logic [POS_W-1:0]   first;
  logic [HOLD_W-1:0]  hcnt;
  logic               pend;
  logic               rd;

  function automatic logic bit_at(input logic [FRAME_W-1:0] f, input logic [POS_W-1:0] p);
    return (p >= POS_W'(FRAME_W)) ? 1'b1 : f[p[$clog2(FRAME_W)-1:0]];
  endfunction

  function automatic logic oe_at(input logic [FRAME_W-1:0] f, input logic [POS_W-1:0] p);
    return !((f[29:28] == OP_READ) && (p <= POS_W'(TA_TOP)));
  endfunction

  assign rd     = (frm_q[29:28] == OP_READ);
  assign pos_dn = pos - 1'b1;
  assign first  = nopre ? POS_W'(FRAME_W - 1) : POS_W'(TOTAL - 1);
  assign done   = active && fall_stb && (pos == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      active  <= 1'b0;
      frm_q   <= '0;
      pos     <= '0;
      hcnt    <= '0;
      pend    <= 1'b0;
      mdio_o  <= 1'b0;
      mdio_oe <= 1'b0;
      rdata   <= '0;
    end else if (!active) begin
      if (start) begin
        active  <= 1'b1;
        frm_q   <= frame;
        pos     <= first;
        pend    <= 1'b0;
        mdio_o  <= bit_at(frame, first);
        mdio_oe <= oe_at(frame, first);
      end
    end else begin
      if (rise_stb && rd && (pos < POS_W'(DATA_W)))
        rdata <= {rdata[DATA_W-2:0], mdio_i};
      if (fall_stb) begin
        if (pos == '0) begin
          active  <= 1'b0;
          pend    <= 1'b0;
          mdio_o  <= 1'b0;
          mdio_oe <= 1'b0;
        end else begin
          pend <= 1'b1;
          hcnt <= hold;
        end
      end else if (pend) begin
        if (hcnt == '0) begin
          pend    <= 1'b0;
          pos     <= pos_dn;
          mdio_o  <= bit_at(frm_q, pos_dn);
          mdio_oe <= oe_at(frm_q, pos_dn);
        end else begin
          hcnt <= hcnt - 1'b1;
        end
      end
    end
  end

  // R5: the line is released only inside a read frame
  a_r5_release_only_read: assert property (@(posedge clk) disable iff (rst)
    (active && !mdio_oe) |-> rd);
  // R1: a running frame is not restarted by a new start request
  a_r1_no_restart: assert property (@(posedge clk) disable iff (rst)
    (active && start && !done) |=> $stable(frm_q));
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int DIV_W  = 6,
  parameter int HOLD_W = 3
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        reg_we,
  input  logic [1:0]  reg_sel,
  input  logic [31:0] reg_wdata,
  output logic [31:0] frame_q,
  output logic        evt,
  output logic        busy,
  output logic        irq,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  logic [DIV_W-1:0]  div_q;
  logic [HOLD_W-1:0] hold_q;
  logic              nopre_q;
  logic              mask_q;
  logic              start;
  logic              done;
  logic              rise_stb;
  logic              fall_stb;
  logic [DATA_W-1:0] rdata;

  assign start = reg_we && (reg_sel == SEL_FRAME) && !busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      frame_q <= '0;
      div_q   <= '0;
      hold_q  <= '0;
      nopre_q <= 1'b0;
      mask_q  <= 1'b0;
      evt     <= 1'b0;
      irq     <= 1'b0;
    end else begin
      if (start)
        frame_q <= reg_wdata;
      else if (done && (frame_q[29:28] == OP_READ))
        frame_q[DATA_W-1:0] <= rdata;
      if (reg_we && (reg_sel == SEL_TIMING)) begin
        div_q   <= reg_wdata[SPD_LSB +: DIV_W];
        hold_q  <= reg_wdata[HOLD_LSB +: HOLD_W];
        nopre_q <= reg_wdata[NOPRE_BIT];
      end
      if (reg_we && (reg_sel == SEL_MASK))
        mask_q <= reg_wdata[EVT_BIT];
      if (done)
        evt <= 1'b1;
      else if (reg_we && (reg_sel == SEL_EVENT) && reg_wdata[EVT_BIT])
        evt <= 1'b0;
      irq <= evt && mask_q;
    end
  end

  mdio_clkgen #(.DIV_W(DIV_W)) u_clk (
    .clk      (clk),
    .rst      (rst),
    .run      (busy),
    .div      (div_q),
    .mdc      (mdc),
    .rise_stb (rise_stb),
    .fall_stb (fall_stb)
  );

  mdio_shifter #(.HOLD_W(HOLD_W)) u_shf (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .frame    (reg_wdata),
    .nopre    (nopre_q),
    .hold     (hold_q),
    .rise_stb (rise_stb),
    .fall_stb (fall_stb),
    .mdio_i   (mdio_i),
    .active   (busy),
    .mdio_o   (mdio_o),
    .mdio_oe  (mdio_oe),
    .done     (done),
    .rdata    (rdata)
  );

  a_r2_mdc_low_idle: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mdc);
  a_r1_ignore_busy_write: assert property (@(posedge clk) disable iff (rst)
    (busy && reg_we && (reg_sel == SEL_FRAME) && !done) |=> $stable(frame_q));
  a_r7_evt_set: assert property (@(posedge clk) disable iff (rst)
    done |=> evt);
  a_r8_irq_follow: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq == $past(evt && mask_q)));
endmodule

// File: tb/tb_mdio_master.sv
module tb_mdio_master;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_sel = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] frame_q;
  logic        evt, busy, irq, mdc, mdio_o, mdio_oe;
  logic        mdio_i = 1'b1;

  int checks = 0;
  int errors = 0;
  bit wd_hit = 1'b0;

  always #2 clk = ~clk;

  mdio_master dut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .frame_q(frame_q), .evt(evt), .busy(busy),
    .irq(irq), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  task automatic check(input string req, input bit ok, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [31:0] data);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = sel; reg_wdata = data;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic run_frame(input logic [31:0] frm, input logic [15:0] reply,
                           input int spd, input int hold, input bit nopre, input bit inject);
    int total, rises, last_rise, last_fall, cyc;
    int bad_seq, bad_per, bad_hold;
    bit pm, po, poe, rd;
    logic [31:0] exp_q;
    total = nopre ? 32 : 64;
    rd = (frm[29:28] == 2'b10);
    rises = 0; last_rise = -1; last_fall = -1000; cyc = 0;
    bad_seq = 0; bad_per = 0; bad_hold = 0;
    wr(2'd1, (32'(spd) << 1) | (32'(hold) << 8) | (32'(nopre) << 7));
    @(negedge clk);
    reg_we = 1'b1; reg_sel = 2'd0; reg_wdata = frm;
    @(negedge clk);
    reg_we = 1'b0;
    pm = mdc; po = mdio_o; poe = mdio_oe;
    while (busy && cyc < 20000) begin
      int p;
      if (inject && cyc == 5) begin
        reg_we = 1'b1; reg_sel = 2'd0; reg_wdata = ~frm;
      end else begin
        reg_we = 1'b0;
      end
      p = total - 1 - rises;
      mdio_i = (p >= 0 && p <= 15) ? reply[p] : 1'b1;
      @(negedge clk);
      cyc++;
      if (mdc && !pm) begin
        bit eoe, eo;
        p = total - 1 - rises;
        eoe = !(rd && p <= 17);
        eo = (p >= 32) ? 1'b1 : frm[p];
        if (mdio_oe !== eoe || (eoe && mdio_o !== eo)) bad_seq++;
        if (last_rise >= 0 && cyc - last_rise != 2 * (spd + 1)) bad_per++;
        last_rise = cyc;
        rises++;
      end
      if (!mdc && pm) last_fall = cyc;
      if (busy && (mdio_o !== po || mdio_oe !== poe) && (cyc - last_fall != hold + 1)) bad_hold++;
      pm = mdc; po = mdio_o; poe = mdio_oe;
    end
    reg_we = 1'b0;
    if (cyc >= 20000) begin
      wd_hit = 1'b1;
      check("R1 watchdog", 1'b0, cyc, 20000);
    end
    check("R4/R5 bit sequence", bad_seq == 0, bad_seq, 0);
    check("R2 mdc period", bad_per == 0, bad_per, 0);
    check("R4 hold offset", bad_hold == 0, bad_hold, 0);
    check("R3 rise count", rises == total, rises, total);
    check("R2 mdc low after frame", mdc == 1'b0, mdc, 0);
    exp_q = rd ? {frm[31:16], reply} : frm;
    @(negedge clk);
    check("R6/R1 frame register", frame_q == exp_q, frame_q, exp_q);
    check("R7 event set", evt == 1'b1, evt, 1);
    wr(2'd2, 32'h0);
    check("R7 zero write keeps event", evt == 1'b1, evt, 1);
    wr(2'd2, 32'h0080_0000);
    check("R7 one write clears event", evt == 1'b0, evt, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R9 frame reset", frame_q == 0, frame_q, 0);
    check("R9 flags reset", {evt, busy, irq, mdc, mdio_oe} == 5'b0, {evt, busy, irq, mdc, mdio_oe}, 0);

    for (int s = 1; s <= 4; s++)
      for (int h = 0; h < s; h++)
        for (int n = 0; n < 2; n++)
          for (int r = 0; r < 2; r++) begin
            logic [31:0] f;
            f = {2'b01, (r != 0) ? 2'b10 : 2'b01, 5'(s * 3 + h), 5'(h * 7 + n), 2'b10,
                 16'hA5C3 ^ 16'(s * 257 + h * 31)};
            run_frame(f, 16'h5A3C ^ 16'(s * 4099 + h), s, h, n != 0, 1'b0);
          end

    // R2 rate example: divider 24 -> 50 module cycles per bit
    run_frame(32'h6123_5678, 16'hBEEF, 24, 3, 1'b1, 1'b0);
    // R1 write while busy ignored (write frame then read frame)
    run_frame(32'h5082_1234, 16'h0000, 2, 1, 1'b1, 1'b1);
    run_frame(32'h60C6_0000, 16'hC3A5, 2, 1, 1'b1, 1'b1);

    // R8 interrupt follows event and mask
    wr(2'd3, 32'h0080_0000);
    @(negedge clk);
    check("R8 no irq without event", irq == 1'b0, irq, 0);
    run_frame(32'h5082_0001, 16'h0, 1, 0, 1'b1, 1'b0);
    wr(2'd0, 32'h5082_0002);
    while (busy) @(negedge clk);
    @(negedge clk);
    check("R8 irq with event and mask", irq == 1'b1, irq, 1);
    wr(2'd3, 32'h0);
    @(negedge clk);
    check("R8 irq masked", irq == 1'b0, irq, 0);
    wr(2'd2, 32'h0080_0000);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    check("R1 global watchdog", 1'b0, 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule